// File: doc/BRIEF.md
# Serial Command-Framed Register Port

This block is the device side of a four-wire serial control link. A host reaches a bank of sixteen byte-wide registers through it. The host pulls an active-low select line, toggles a serial clock, and moves bytes most-significant bit first. The block samples the input line on rising serial-clock edges and changes its output on falling edges. The serial signals are oversampled by the block's own system clock, so the rest of the logic lives in one clock domain.

After select falls, the first byte is the command. Every later byte in that select window is data. On a write, each complete data byte goes into the addressed register, and the address then steps forward. On a read, the block first sends a fixed identification byte. It then streams register contents while it disregards the input line. Raising select ends the window at once, and a fresh command needs a new window.

Top module: `sercmd_regport`

## Requirements
- R1: After reset, and from a few system clocks after select goes high, the output enable `sdo_oe` is low. All sixteen registers read back as 0x00 after reset.
- R2: Bytes travel most-significant bit first. The command byte is decoded as follows: bit 7 = 1 means read and 0 means write, bits 3..0 hold the starting address, and bits 6..4 must be zero.
- R3: On a write, a data byte is stored only when all 8 of its bits have arrived. Each further byte goes to the next address, and the address wraps from 15 to 0.
- R4: On a read, the output carries 0x81 first. It then carries the registers from the starting address upward, wrapping from 15 to 0. `sdo` changes only after falling serial-clock edges, so the host can sample it on rising edges.
- R5: A byte that follows the command in the same select window is always data, even when its bit pattern would be a valid command.
- R6: While a read is in progress, the input line has no effect: no register changes and the output sequence does not change.
- R7: Raising select aborts the transfer. A partially received byte is discarded, and bytes already completed stay stored.
- R8: `sdo_oe` stays low during write windows. A command with any of bits 6..4 set is ignored: its data bytes are not stored and the output is never enabled in that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select; one command per low window |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Output enable for `sdo`; low means high impedance |

## Verification
The assertions take three things for granted about the inputs. The serial clock is slow enough that every level lasts several system clocks. Select and data only change while the serial clock is low, well clear of a rising edge. The three serial lines pass through synchronisers of equal depth, so their edges stay in step. The bench holds each serial-clock phase for five system clocks. It changes data and select only in the low phase and offsets every host action from the system clock edge. Under these conditions, the register-bank and output-enable properties hold for the random mix of reads, writes and aborted windows.

// File: rtl/sercmd_regport.sv
module sercmd_regport #(
  parameter int         ADDR_W  = 4,
  parameter logic [7:0] ID_CODE = 8'h81
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic sdi,
  output logic sdo,
  output logic sdo_oe
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [1:0] PH_CMD = 2'd0, PH_WR = 2'd1, PH_RD = 2'd2, PH_SKIP = 2'd3;

  logic [2:0] sclk_s;
  logic [1:0] cs_s, sdi_s;
  logic [1:0] phase;
  logic [2:0] bcnt, ocnt;
  logic [6:0] sr;
  logic [7:0] obuf;
  logic [ADDR_W-1:0] addr;
  logic [DEPTH-1:0][7:0] bank;

  wire sclk_rise = sclk_s[1] & ~sclk_s[2];
  wire sclk_fall = ~sclk_s[1] & sclk_s[2];
  wire cs_idle   = cs_s[1];
  wire [7:0] rx_byte = {sr, sdi_s[1]};
  wire byte_done = sclk_rise & ~cs_idle & (bcnt == 3'd7) & (phase != PH_RD);
  wire wr_en     = byte_done & (phase == PH_WR);
  wire cmd_ok    = (rx_byte[6:ADDR_W] == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_s <= '0;
      cs_s   <= 2'b11;
      sdi_s  <= '0;
    end else begin
      sclk_s <= {sclk_s[1:0], sclk};
      cs_s   <= {cs_s[0], cs_n};
      sdi_s  <= {sdi_s[0], sdi};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase  <= PH_CMD;
      bcnt   <= '0;
      ocnt   <= '0;
      sr     <= '0;
      obuf   <= '0;
      addr   <= '0;
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end else if (cs_idle) begin
      phase  <= PH_CMD;
      bcnt   <= '0;
      ocnt   <= '0;
      sdo_oe <= 1'b0;
    end else begin
      if (sclk_rise && phase != PH_RD) begin
        sr   <= rx_byte[6:0];
        bcnt <= bcnt + 3'd1;
      end
      if (byte_done) begin
        case (phase)
          PH_CMD: begin
            addr <= rx_byte[ADDR_W-1:0];
            if (!cmd_ok) phase <= PH_SKIP;
            else if (rx_byte[7]) begin
              phase <= PH_RD;
              obuf  <= ID_CODE;
              ocnt  <= '0;
            end else phase <= PH_WR;
          end
          PH_WR:   addr <= addr + 1'b1;
          default: ;
        endcase
      end
      if (sclk_fall && phase == PH_RD) begin
        sdo    <= obuf[7];
        sdo_oe <= 1'b1;
        ocnt   <= ocnt + 3'd1;
        if (ocnt == 3'd7) begin
          obuf <= bank[addr];
          addr <= addr + 1'b1;
        end else obuf <= {obuf[6:0], 1'b0};
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bank <= '0;
    else if (wr_en) bank[addr] <= rx_byte;
endmodule

module sercmd_regport_chk #(
  parameter int BANK_W = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_idle,
  input logic              sclk_fall,
  input logic              in_rd,
  input logic              in_wr,
  input logic              sdo,
  input logic              sdo_oe,
  input logic [2:0]        bcnt,
  input logic [BANK_W-1:0] bank
);
  AST_OE_OFF_IDLE:   assert property (@(posedge clk) disable iff (!rst_n) cs_idle |=> !sdo_oe);       // R1
  AST_SDO_ON_FALL:   assert property (@(posedge clk) disable iff (!rst_n) !sclk_fall |=> $stable(sdo)); // R4
  AST_BANK_WR_ONLY:  assert property (@(posedge clk) disable iff (!rst_n) !in_wr |=> $stable(bank));   // R6
  AST_ABORT_CLEARS:  assert property (@(posedge clk) disable iff (!rst_n) cs_idle |=> bcnt == 3'd0);   // R7
  AST_OE_ONLY_READ:  assert property (@(posedge clk) disable iff (!rst_n) sdo_oe |-> in_rd);           // R8
endmodule

bind sercmd_regport sercmd_regport_chk #(.BANK_W($bits(bank))) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle), .sclk_fall(sclk_fall),
  .in_rd(phase == PH_RD), .in_wr(phase == PH_WR),
  .sdo(sdo), .sdo_oe(sdo_oe), .bcnt(bcnt), .bank(bank)
);

// File: tb/sercmd_regport_bench.sv
`timescale 1ns/1ps
module sercmd_regport_bench;
  localparam int HP = 100;
  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic sdo, sdo_oe;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] mdl [16];
  logic [7:0] wbuf [8];

  sercmd_regport u_sercmd_regport (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
                                   .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe));

  always #10 clk = ~clk;

  function automatic logic [7:0] cmd_byte(input bit rd, input logic [3:0] a);
    return {rd, 3'b000, a};
  endfunction

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx, inout bit oe_seen);
    rx = '0;
    for (int i = 0; i < nbits; i++) begin
      sdi = tx[7-i];
      #HP;
      rx = {rx[6:0], sdo};
      oe_seen |= sdo_oe;
      sclk = 1'b1;
      #HP;
      sclk = 1'b0;
    end
  endtask

  task automatic open_win();  cs_n = 1'b0; #HP; endtask
  task automatic close_win(); #HP; cs_n = 1'b1; #(4*HP); endtask

  task automatic do_write(input logic [3:0] a, input int n, input string req);
    logic [7:0] rx; bit oe = 0;
    open_win();
    xfer(cmd_byte(0, a), 8, rx, oe);
    for (int i = 0; i < n; i++) begin
      xfer(wbuf[i], 8, rx, oe);
      mdl[4'(a + i)] = wbuf[i];
    end
    close_win();
    check(!oe, "R8 oe during write", {7'd0, oe}, 8'h00);
  endtask

  task automatic do_read(input logic [3:0] a, input int n, input logic [7:0] fill, input string req);
    logic [7:0] rx; bit oe = 0;
    open_win();
    xfer(cmd_byte(1, a), 8, rx, oe);
    xfer(fill, 8, rx, oe);
    check(rx == 8'h81, "R4 id byte", rx, 8'h81);
    for (int i = 0; i < n; i++) begin
      xfer(fill, 8, rx, oe);
      check(rx == mdl[4'(a + i)], req, rx, mdl[4'(a + i)]);
    end
    check(oe, "R4 oe during read", {7'd0, oe}, 8'h01);
    close_win();
  endtask

  initial begin
    #2_600_000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx; bit oe;
    void'($urandom(32'h5eed));
    for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
    #53 rst_n = 1'b1;
    #200;
    check(sdo_oe == 1'b0, "R1 oe after reset", {7'd0, sdo_oe}, 8'h00);
    do_read(4'd0, 16, 8'h00, "R1 reset contents");

    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3; wbuf[3] = 8'hD4;
    do_write(4'd14, 4, "R3");
    do_read(4'd14, 4, 8'h00, "R3 R4 wrap");
    do_read(4'd0, 16, 8'h00, "R2 R3 full bank");

    for (int t = 0; t < 40; t++) begin
      logic [3:0] a = 4'($urandom_range(15));
      int n = $urandom_range(1, 6);
      if ($urandom_range(1)) begin
        for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
        do_write(a, n, "R3 random");
      end else do_read(a, n, 8'($urandom), "R4 random");
    end

    wbuf[0] = 8'h85; wbuf[1] = 8'h07;
    do_write(4'd3, 2, "R5");
    do_read(4'd3, 2, 8'h00, "R5 data not command");

    do_read(4'd5, 6, 8'h0A, "R6 input ignored");
    do_read(4'd5, 6, 8'hFF, "R6 input ignored ones");
    do_read(4'd0, 16, 8'h00, "R6 bank unchanged");

    oe = 0;
    open_win();
    xfer(cmd_byte(0, 4'd8), 8, rx, oe);
    xfer(8'h3C, 8, rx, oe);
    xfer(8'hAA, 5, rx, oe);
    close_win();
    mdl[8] = 8'h3C;
    do_read(4'd8, 2, 8'h00, "R7 partial discarded");

    oe = 0;
    open_win();
    xfer(8'h12, 8, rx, oe);
    xfer(8'h55, 8, rx, oe);
    close_win();
    check(!oe, "R8 reserved write oe", {7'd0, oe}, 8'h00);
    oe = 0;
    open_win();
    xfer(8'hA2, 8, rx, oe);
    xfer(8'h00, 8, rx, oe);
    xfer(8'h00, 8, rx, oe);
    close_win();
    check(!oe, "R8 reserved read oe", {7'd0, oe}, 8'h00);
    do_read(4'd2, 1, 8'h00, "R8 reserved write ignored");

    #HP;
    check(sdo_oe == 1'b0, "R1 oe idle", {7'd0, sdo_oe}, 8'h00);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule